// File: doc/BRIEF.md
# Register-Based Page Map Unit

This block maps 16-bit logical addresses onto a wider physical address space through a small page table. The table lives entirely in eight dedicated registers. The three top bits of the logical address pick one entry. That entry gives an 8-bit frame number, and the frame number is placed in front of the 13-bit page offset, which passes through unchanged. The result is a 21-bit physical address. The lookup is purely combinational, so a memory access that goes through the map costs no extra cycle.

The table can only be changed through a write port that is guarded by a privilege input. When the supervisor dispatcher switches context, it rewrites all eight entries, one per cycle, from the values saved for the incoming process. If a write is attempted while the privilege input is low, the write is dropped and a one-cycle error pulse is raised. Each entry also carries a valid bit. A lookup through an entry that is not valid raises a fault and returns a physical address of zero. Reset marks every entry not valid.

Top module: `page_map_unit`

## Requirements
- R1: The page number is `lookup_addr[15:13]` and the offset is `lookup_addr[12:0]`. When the selected entry is valid, `phys_addr` equals `{frame, lookup_addr[12:0]}` (21 bits) and `fault` is low.
- R2: Translation is combinational. `phys_addr` and `fault` follow a change on `lookup_addr` within the same clock cycle, with no clock edge needed.
- R3: The eight entries are independent. A write to one index leaves the translation of every other page unchanged.
- R4: When `wr_en` and `supervisor` are both high at a rising edge, the entry at `wr_index` takes `wr_frame` and `wr_valid`. Lookups see the new contents from that edge on, and not before it.
- R5: When `wr_en` is high and `supervisor` is low at a rising edge, no entry changes.
- R6: A rejected write of this kind drives `privilege_error` high for exactly the one cycle that follows the edge that sampled it. `privilege_error` is low at all other times, including after accepted writes.
- R7: When the selected entry's valid bit is clear, `fault` is high and `phys_addr` is zero.
- R8: Driving `rst_n` low clears every valid bit and `privilege_error` at once, without waiting for a clock. Reset is released internally on the second rising edge after `rst_n` goes high.
- R9: A full reload of all eight entries replaces the whole map. Writing `wr_valid` = 0 to an entry turns it into a faulting page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supervisor | input | 1 | High when the requester is in privileged mode |
| wr_en | input | 1 | Request to write one table entry |
| wr_index | input | 3 | Entry (page number) to write |
| wr_frame | input | 8 | Frame number to store |
| wr_valid | input | 1 | Valid bit to store |
| lookup_addr | input | 16 | Logical address to translate |
| phys_addr | output | 21 | Translated physical address, zero on fault |
| fault | output | 1 | Selected entry is not valid |
| privilege_error | output | 1 | One-cycle pulse after a rejected write |

## Verification
The main check loads a known map with page 7 left not valid. It then walks a table of addresses that cover the lowest and highest offsets, every valid page, and both ends of the not-valid page. This catches a wrong split between page bits and offset bits, a wrong frame being selected, and a fault path that leaks address bits. Directed patterns then cover several cases:
- a user-mode write aimed at a live entry, to separate a dropped write from an accepted one;
- a single supervisor write with its neighbours checked, to catch index decode errors;
- a complete reload, to confirm that every entry can be replaced;
- an address change between clock edges, to confirm that the lookup is combinational;
- reset asserted in the middle of the run.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned PMU_LADDR_W_DEF = 16;
  localparam int unsigned PMU_PAGE_W_DEF  = 3;
  localparam int unsigned PMU_FRAME_W_DEF = 8;
endpackage

// File: rtl/pmu_reset_sync.sv
module pmu_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign core_rst_n = stage2_q;
endmodule

// File: rtl/pmu_write_gate.sv
module pmu_write_gate #(
  parameter int unsigned PAGE_W  = pmu_pkg::PMU_PAGE_W_DEF,
  localparam int unsigned ENTRIES = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              supervisor,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_index,
  output logic [ENTRIES-1:0] entry_we,
  output logic              privilege_error
);
  logic accept;
  logic err_d;
  logic err_q;

  always_comb begin
    accept = wr_en & supervisor;
    err_d  = wr_en & ~supervisor;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
    assign entry_we[g] = accept & (wr_index == PAGE_W'(g));
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign privilege_error = err_q;
endmodule

// File: rtl/pmu_entry_reg.sv
module pmu_entry_reg #(
  parameter int unsigned FRAME_W = pmu_pkg::PMU_FRAME_W_DEF
) (
  input  logic               clk,
  input  logic               core_rst_n,
  input  logic               we,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               valid_in,
  output logic [FRAME_W-1:0] frame_q,
  output logic               valid_q
);
  logic [FRAME_W-1:0] frame_d;
  logic               valid_d;
  logic [FRAME_W-1:0] frame_r;
  logic               valid_r;

  always_comb begin
    frame_d = frame_r;
    valid_d = valid_r;
    if (we) begin
      frame_d = frame_in;
      valid_d = valid_in;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) valid_r <= 1'b0;
    else if (we)     valid_r <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (we) frame_r <= frame_d;
  end

  assign frame_q = frame_r;
  assign valid_q = valid_r;
endmodule

// File: rtl/pmu_lookup.sv
module pmu_lookup #(
  parameter int unsigned LADDR_W = pmu_pkg::PMU_LADDR_W_DEF,
  parameter int unsigned PAGE_W  = pmu_pkg::PMU_PAGE_W_DEF,
  parameter int unsigned FRAME_W = pmu_pkg::PMU_FRAME_W_DEF,
  localparam int unsigned ENTRIES = 1 << PAGE_W,
  localparam int unsigned OFF_W   = LADDR_W - PAGE_W,
  localparam int unsigned PADDR_W = FRAME_W + OFF_W
) (
  input  logic [LADDR_W-1:0]         lookup_addr,
  input  logic [ENTRIES-1:0]         valid_vec,
  input  logic [ENTRIES*FRAME_W-1:0] frame_vec,
  output logic [PADDR_W-1:0]         phys_addr,
  output logic                       fault
);
  logic [PAGE_W-1:0]  page;
  logic [OFF_W-1:0]   offset;
  logic [FRAME_W-1:0] frame_sel;
  logic               hit;

  always_comb begin
    page      = lookup_addr[LADDR_W-1 -: PAGE_W];
    offset    = lookup_addr[OFF_W-1:0];
    hit       = valid_vec[page];
    frame_sel = frame_vec[page*FRAME_W +: FRAME_W];
    fault     = ~hit;
    phys_addr = hit ? {frame_sel, offset} : '0;
  end
endmodule

// File: rtl/page_map_unit.sv
module page_map_unit #(
  parameter int unsigned LADDR_W = pmu_pkg::PMU_LADDR_W_DEF,
  parameter int unsigned PAGE_W  = pmu_pkg::PMU_PAGE_W_DEF,
  parameter int unsigned FRAME_W = pmu_pkg::PMU_FRAME_W_DEF,
  localparam int unsigned ENTRIES = 1 << PAGE_W,
  localparam int unsigned OFF_W   = LADDR_W - PAGE_W,
  localparam int unsigned PADDR_W = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               supervisor,
  input  logic               wr_en,
  input  logic [PAGE_W-1:0]  wr_index,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_valid,
  input  logic [LADDR_W-1:0] lookup_addr,
  output logic [PADDR_W-1:0] phys_addr,
  output logic               fault,
  output logic               privilege_error
);
  logic                       core_rst_n;
  logic [ENTRIES-1:0]         entry_we;
  logic [ENTRIES-1:0]         valid_q;
  logic [ENTRIES*FRAME_W-1:0] frame_q;

  pmu_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  pmu_write_gate #(.PAGE_W(PAGE_W)) u_gate (
    .clk             (clk),
    .core_rst_n      (core_rst_n),
    .supervisor      (supervisor),
    .wr_en           (wr_en),
    .wr_index        (wr_index),
    .entry_we        (entry_we),
    .privilege_error (privilege_error)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    pmu_entry_reg #(.FRAME_W(FRAME_W)) u_ent (
      .clk        (clk),
      .core_rst_n (core_rst_n),
      .we         (entry_we[g]),
      .frame_in   (wr_frame),
      .valid_in   (wr_valid),
      .frame_q    (frame_q[g*FRAME_W +: FRAME_W]),
      .valid_q    (valid_q[g])
    );
  end

  pmu_lookup #(.LADDR_W(LADDR_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_lkp (
    .lookup_addr (lookup_addr),
    .valid_vec   (valid_q),
    .frame_vec   (frame_q),
    .phys_addr   (phys_addr),
    .fault       (fault)
  );
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PAGE_W  = 3,
  parameter int unsigned FRAME_W = 8,
  localparam int unsigned ENTRIES = 1 << PAGE_W,
  localparam int unsigned OFF_W   = LADDR_W - PAGE_W,
  localparam int unsigned PADDR_W = FRAME_W + OFF_W
) (
  input logic                       clk,
  input logic                       core_rst_n,
  input logic                       supervisor,
  input logic                       wr_en,
  input logic [PAGE_W-1:0]          wr_index,
  input logic [FRAME_W-1:0]         wr_frame,
  input logic                       wr_valid,
  input logic [LADDR_W-1:0]         lookup_addr,
  input logic [PADDR_W-1:0]         phys_addr,
  input logic                       fault,
  input logic                       privilege_error,
  input logic [ENTRIES-1:0]         valid_q,
  input logic [ENTRIES*FRAME_W-1:0] frame_q
);
  logic [PAGE_W-1:0]  idx_d;
  logic [FRAME_W-1:0] frm_d;
  logic               vld_d;

  always_ff @(posedge clk) begin
    idx_d <= wr_index;
    frm_d <= wr_frame;
    vld_d <= wr_valid;
  end

  // R8: while reset is held, no entry is valid
  assert_reset_clears_R8: assert property (@(posedge clk)
    !core_rst_n |-> (valid_q == '0 && !privilege_error));

  assert_fault_zero_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    fault |-> (phys_addr == '0));

  assert_valid_no_fault_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    valid_q[lookup_addr[LADDR_W-1 -: PAGE_W]] |->
      (!fault && phys_addr[OFF_W-1:0] == lookup_addr[OFF_W-1:0]));

  assert_reject_pulse_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && !supervisor) |=> privilege_error);

  assert_error_cause_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    privilege_error |-> $past(wr_en && !supervisor));

  assert_reject_stable_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && !supervisor) |=> ($stable(valid_q) && $stable(frame_q)));

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && supervisor) |=>
      (valid_q[idx_d] == vld_d && frame_q[idx_d*FRAME_W +: FRAME_W] == frm_d));
endmodule

bind page_map_unit pmu_checker #(.LADDR_W(LADDR_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_chk (
  .clk             (clk),
  .core_rst_n      (core_rst_n),
  .supervisor      (supervisor),
  .wr_en           (wr_en),
  .wr_index        (wr_index),
  .wr_frame        (wr_frame),
  .wr_valid        (wr_valid),
  .lookup_addr     (lookup_addr),
  .phys_addr       (phys_addr),
  .fault           (fault),
  .privilege_error (privilege_error),
  .valid_q         (valid_q),
  .frame_q         (frame_q)
);

// File: tb/page_map_unit_test.sv
module page_map_unit_test;
  logic        clk;
  logic        rst_n;
  logic        supervisor;
  logic        wr_en;
  logic [2:0]  wr_index;
  logic [7:0]  wr_frame;
  logic        wr_valid;
  logic [15:0] lookup_addr;
  logic [20:0] phys_addr;
  logic        fault;
  logic        privilege_error;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  page_map_unit uut (
    .clk(clk), .rst_n(rst_n), .supervisor(supervisor), .wr_en(wr_en),
    .wr_index(wr_index), .wr_frame(wr_frame), .wr_valid(wr_valid),
    .lookup_addr(lookup_addr), .phys_addr(phys_addr), .fault(fault),
    .privilege_error(privilege_error)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {addr, expected phys, expected fault}; page 7 is left not valid
  localparam logic [37:0] VECS [0:9] = '{
    {16'h0000, 21'h024000, 1'b0},
    {16'h1FFF, 21'h025FFF, 1'b0},
    {16'h2005, 21'h068005, 1'b0},
    {16'h5ABC, 21'h0ADABC, 1'b0},
    {16'h6001, 21'h0F0001, 1'b0},
    {16'h8123, 21'h134123, 1'b0},
    {16'hA7FF, 21'h1787FF, 1'b0},
    {16'hDEAD, 21'h1BDEAD, 1'b0},
    {16'hFFFF, 21'h000000, 1'b1},
    {16'hE000, 21'h000000, 1'b1}
  };
  localparam logic [7:0] MAP [0:6] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_entry(input logic sup, input logic [2:0] idx,
                             input logic [7:0] frm, input logic vld);
    @(negedge clk);
    supervisor = sup; wr_en = 1'b1; wr_index = idx; wr_frame = frm; wr_valid = vld;
    @(negedge clk);
    wr_en = 1'b0; supervisor = 1'b0;
  endtask

  task automatic probe(input string req, input logic [15:0] a,
                       input logic [20:0] ep, input logic ef);
    lookup_addr = a;
    #1;
    check(req, {11'd0, phys_addr}, {11'd0, ep});
    check(req, {31'd0, fault}, {31'd0, ef});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; supervisor = 1'b0; wr_en = 1'b0; wr_index = '0;
    wr_frame = '0; wr_valid = 1'b0; lookup_addr = '0;
    #5 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: every page faults in reset
    probe("R8 reset", 16'h0000, 21'h0, 1'b1);
    probe("R8 reset", 16'hC123, 21'h0, 1'b1);
    check("R8 reset err", {31'd0, privilege_error}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Load map: R9 full reload
    for (int i = 0; i < 7; i++) write_entry(1'b1, 3'(i), MAP[i], 1'b1);
    write_entry(1'b1, 3'd7, 8'h77, 1'b0);
    check("R6 no err on accepted", {31'd0, privilege_error}, 32'd0);

    // Table walk: R1 / R7
    for (int i = 0; i < 10; i++) begin
      probe(VECS[i][0] ? "R7 invalid page" : "R1 translate",
            VECS[i][37:22], VECS[i][21:1], VECS[i][0]);
    end

    // R2: combinational change between edges
    @(negedge clk);
    #3;
    probe("R2 comb", 16'h2005, 21'h068005, 1'b0);
    probe("R2 comb", 16'hE000, 21'h0, 1'b1);

    // R5/R6: user-mode write rejected
    write_entry(1'b0, 3'd0, 8'hFF, 1'b1);
    check("R6 pulse", {31'd0, privilege_error}, 32'd1);
    probe("R5 unchanged", 16'h0000, 21'h024000, 1'b0);
    @(negedge clk);
    check("R6 one cycle", {31'd0, privilege_error}, 32'd0);
    write_entry(1'b0, 3'd7, 8'h01, 1'b1);
    probe("R5 unchanged inv", 16'hE000, 21'h0, 1'b1);

    // R4: write timing, R3: neighbours intact
    @(negedge clk);
    supervisor = 1'b1; wr_en = 1'b1; wr_index = 3'd2; wr_frame = 8'h01; wr_valid = 1'b1;
    probe("R4 before edge", 16'h4010, 21'h0AC010, 1'b0);
    @(negedge clk);
    wr_en = 1'b0; supervisor = 1'b0;
    probe("R4 after edge", 16'h4010, 21'h002010, 1'b0);
    probe("R3 page1", 16'h3FFF, 21'h069FFF, 1'b0);
    probe("R3 page3", 16'h6001, 21'h0F0001, 1'b0);

    // R9: reload all with new frames, then invalidate page 0
    for (int i = 0; i < 8; i++) write_entry(1'b1, 3'(i), 8'hF0 + 8'(i), 1'b1);
    probe("R9 reload p7", 16'hE004, 21'h1EE004, 1'b0);
    probe("R9 reload p2", 16'h4000, 21'h1E4000, 1'b0);
    write_entry(1'b1, 3'd0, 8'hAA, 1'b0);
    probe("R9 invalidate", 16'h0123, 21'h0, 1'b1);

    // R8: asynchronous reset mid-run
    @(negedge clk);
    #2 rst_n = 1'b0;
    probe("R8 async", 16'hE004, 21'h0, 1'b1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    probe("R8 after release", 16'h4000, 21'h0, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule